// File: doc/BRIEF.md
# Bus-Master Channel Control Registers

This block is the register front end of one bus-master disk DMA channel. Software reads and writes a command byte, a status byte and a 32-bit descriptor-table base through a byte-addressed port that accepts 1, 2 or 4 byte accesses. The block turns command writes into one-cycle strobes for a separate descriptor walker: reload the table pointer, start the engine, or cancel a transfer. It also keeps the channel-active flag that the engine updates when it finishes a piece of work.

The drive interrupt is passed on to the host after one register stage. Its rising edge latches a sticky interrupt flag in status, which software clears by writing a 1. An error input from the engine sets a second sticky flag that clears the same way. Reads have no side effects. The read data is a combinational view of the register image at the addressed byte.

Top module: `dma_ctl_regs`

## Requirements
- R1: After reset every readable byte is zero, and host_irq, eng_kick, eng_cancel, eng_reload, eng_dir and tbl_ptr are all zero.
- R2: A write to byte 0 (command) stores only bit 0 (run) and bit 3 (direction). Reading byte 0 returns the written value ANDed with 0x09. eng_dir equals bit 3.
- R3: A command write whose bit 0 equals the stored run bit issues no kick, cancel or reload strobe and leaves the active flag unchanged.
- R4: A command write that changes run from 1 to 0 pulses eng_cancel for exactly the cycle after the write and clears the active flag.
- R5: A command write that changes run from 0 to 1 pulses eng_reload and loads tbl_ptr from the base value held before that write. If the active flag was clear, it sets the flag and also pulses eng_kick, but only when eng_req_pending is high. If the flag was already set, no kick is issued.
- R6: A write at bytes 4 to 7 (base) replaces only the bytes selected by offset and size. Size encodings are 0 for 1 byte, 1 for 2 bytes, and 2 or 3 for 4 bytes. Bits 1:0 of the base always read zero.
- R7: A read returns the 8-byte image {base[31:0], 0x00, status, 0x00, command}, shifted right by 8 × offset and masked to the access size. Byte 0 is the least significant byte of the image.
- R8: host_irq equals drv_irq delayed by one cycle, for both levels. A rising drv_irq sets status bit 2. A falling drv_irq leaves status unchanged.
- R9: Status bit 0 is the active flag and is read-only to software. Writing a 1 to status bit 1 (error) or bit 2 (interrupt) clears it. eng_err sets bit 1. A set condition in the same cycle as a clear wins.
- R10: When eng_done is high, the active flag takes the value of eng_more. A command write in the same cycle overrides this as in R4 and R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_off | input | 3 | Byte offset of the access |
| reg_size | input | 2 | Access size code (0: 1 byte, 1: 2 bytes, 2/3: 4 bytes) |
| reg_wdata | input | 32 | Write data, right-aligned to the offset |
| reg_rdata | output | 32 | Read data for offset and size |
| drv_irq | input | 1 | Interrupt level from the drive |
| host_irq | output | 1 | Interrupt level to the host |
| eng_req_pending | input | 1 | Engine has a transfer request waiting |
| eng_done | input | 1 | Engine finished a piece of work |
| eng_more | input | 1 | With eng_done: more work remains |
| eng_err | input | 1 | Engine reports an error |
| eng_kick | output | 1 | One-cycle start pulse to the engine |
| eng_cancel | output | 1 | One-cycle cancel pulse to the engine |
| eng_reload | output | 1 | One-cycle pulse: tbl_ptr was reloaded |
| eng_dir | output | 1 | Transfer direction from command bit 3 |
| tbl_ptr | output | 32 | Current descriptor-table pointer |

## Verification
A wrong run bit or active flag shows up at the next command write: a missing or extra strobe appears one cycle after it, and the status byte reads differently in that same cycle. A corrupted base byte or alignment bit is visible on the very next read of bytes 4 to 7, and in tbl_ptr one cycle after the next start. Interrupt faults show in host_irq and status bit 2 in the cycle right after a drv_irq edge. For that reason the bench compares every output and the read data against a behavioural model on every clock.

// File: rtl/dma_ctl_pkg.sv
package dma_ctl_pkg;

  // access size codes on reg_size
  typedef enum logic [1:0] {
    ACC_BYTE  = 2'd0,
    ACC_HALF  = 2'd1,
    ACC_WORD  = 2'd2,
    ACC_WORD3 = 2'd3
  } acc_size_e;

  // byte lane of each register inside the image
  localparam int LANE_CMD  = 0;
  localparam int LANE_STAT = 2;
  localparam int LANE_BASE = 4;

  // bit positions inside the command and status bytes
  localparam int CMD_RUN   = 0;
  localparam int CMD_DIR   = 3;
  localparam int ST_ACTIVE = 0;
  localparam int ST_ERR    = 1;
  localparam int ST_IRQ    = 2;

  // bytes covered by an access, capped at the bus width
  function automatic int acc_bytes(input logic [1:0] sz, input int bus_bytes);
    int n;
    n = 1 << sz;
    if (n > bus_bytes) n = bus_bytes;
    return n;
  endfunction

endpackage

// File: rtl/dma_ctl_lanes.sv
module dma_ctl_lanes
  import dma_ctl_pkg::*;
#(
  parameter int NLANES = 8,
  parameter int DATA_W = 32,
  localparam int OFF_W = $clog2(NLANES),
  localparam int IMG_W = NLANES * 8
) (
  input  logic                   wr,
  input  logic [OFF_W-1:0]       off,
  input  logic [1:0]             size,
  input  logic [DATA_W-1:0]      wdata,
  input  logic [IMG_W-1:0]       image,
  output logic [NLANES-1:0]      lane_we,
  output logic [NLANES-1:0][7:0] lane_byte,
  output logic [DATA_W-1:0]      rdata
);

  localparam int BUS_BYTES = DATA_W / 8;

  logic [IMG_W-1:0]  wide_w;
  logic [IMG_W-1:0]  wide_r;
  logic [DATA_W-1:0] rmask;
  int                nbytes;

  always_comb begin
    nbytes = acc_bytes(size, BUS_BYTES);
    wide_w = {{(IMG_W-DATA_W){1'b0}}, wdata} << {off, 3'b000};
    wide_r = image >> {off, 3'b000};
    rmask  = {DATA_W{1'b1}} >> (DATA_W - 8 * nbytes);
    rdata  = wide_r[DATA_W-1:0] & rmask;
  end

  for (genvar i = 0; i < NLANES; i++) begin : g_lane
    assign lane_we[i]   = wr && (int'(off) <= i) && (i < int'(off) + nbytes);
    assign lane_byte[i] = wide_w[8*i +: 8];
  end

endmodule

// File: rtl/dma_ctl_base.sv
module dma_ctl_base #(
  parameter int AW = 32,
  localparam int NB = AW / 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NB-1:0]      lane_we,
  input  logic [NB-1:0][7:0] lane_byte,
  input  logic               load_ptr,
  output logic [AW-1:0]      base_q,
  output logic [AW-1:0]      ptr_q
);

  logic [AW-1:0] base_d;
  logic [AW-1:0] ptr_d;
  logic          base_en;

  for (genvar i = 0; i < NB; i++) begin : g_byte
    assign base_d[8*i +: 8] = lane_we[i] ? lane_byte[i] : base_q[8*i +: 8];
  end

  always_comb begin
    base_en = |lane_we;
    ptr_d   = base_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
    end else if (base_en) begin
      base_q <= {base_d[AW-1:2], 2'b00};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (load_ptr) begin
      ptr_q <= ptr_d;
    end
  end

  // R6: untouched base holds its value
  a_r6_base_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(|lane_we) |=> $stable(base_q));
  // R6: low two bits of base never set
  a_r6_base_align: assert property (@(posedge clk) disable iff (!rst_n)
    lane_we[0] |=> base_q[1:0] == 2'b00);
  // R5: pointer takes the base seen at the start write
  a_r5_ptr_load: assert property (@(posedge clk) disable iff (!rst_n)
    load_ptr |=> ptr_q == $past(base_q));

endmodule

// File: rtl/dma_ctl_cmd.sv
module dma_ctl_cmd
  import dma_ctl_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_we,
  input  logic [7:0] cmd_byte,
  input  logic       stat_we,
  input  logic [7:0] stat_byte,
  input  logic       drv_irq,
  input  logic       eng_req_pending,
  input  logic       eng_done,
  input  logic       eng_more,
  input  logic       eng_err,
  output logic       run_q,
  output logic       dir_q,
  output logic       act_q,
  output logic       err_q,
  output logic       irqst_q,
  output logic       host_irq_q,
  output logic       kick_q,
  output logic       cancel_q,
  output logic       reload_q,
  output logic       load_ptr
);

  logic run_d, dir_d, act_d, err_d, irqst_d;
  logic kick_d, cancel_d, reload_d;
  logic irq_rise;
  logic start_edge, stop_edge;

  always_comb begin
    irq_rise   = drv_irq && !host_irq_q;
    start_edge = cmd_we && (cmd_byte[CMD_RUN] != run_q) && cmd_byte[CMD_RUN];
    stop_edge  = cmd_we && (cmd_byte[CMD_RUN] != run_q) && !cmd_byte[CMD_RUN];
    load_ptr   = start_edge;

    run_d    = run_q;
    dir_d    = dir_q;
    act_d    = act_q;
    err_d    = err_q;
    irqst_d  = irqst_q;
    kick_d   = 1'b0;
    cancel_d = 1'b0;
    reload_d = 1'b0;

    if (eng_done) act_d = eng_more;

    if (stat_we && stat_byte[ST_ERR]) err_d   = 1'b0;
    if (stat_we && stat_byte[ST_IRQ]) irqst_d = 1'b0;
    if (eng_err)  err_d   = 1'b1;
    if (irq_rise) irqst_d = 1'b1;

    if (cmd_we) begin
      run_d = cmd_byte[CMD_RUN];
      dir_d = cmd_byte[CMD_DIR];
    end
    if (stop_edge) begin
      cancel_d = 1'b1;
      act_d    = 1'b0;
    end
    if (start_edge) begin
      reload_d = 1'b1;
      if (!act_q) begin
        act_d  = 1'b1;
        kick_d = eng_req_pending;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q      <= 1'b0;
      dir_q      <= 1'b0;
      act_q      <= 1'b0;
      err_q      <= 1'b0;
      irqst_q    <= 1'b0;
      host_irq_q <= 1'b0;
      kick_q     <= 1'b0;
      cancel_q   <= 1'b0;
      reload_q   <= 1'b0;
    end else begin
      run_q      <= run_d;
      dir_q      <= dir_d;
      act_q      <= act_d;
      err_q      <= err_d;
      irqst_q    <= irqst_d;
      host_irq_q <= drv_irq;
      kick_q     <= kick_d;
      cancel_q   <= cancel_d;
      reload_q   <= reload_d;
    end
  end

  // R3: unchanged run bit gives no strobe
  a_r3_same_run_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_we && (cmd_byte[CMD_RUN] == run_q) && !eng_done
    |=> !kick_q && !cancel_q && !reload_q && $stable(act_q));
  // R4: stop cancels and drops active
  a_r4_stop_cancel: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_we && !cmd_byte[CMD_RUN] && run_q |=> cancel_q && !act_q);
  // R5: start from idle sets active and reloads
  a_r5_start_idle: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_we && cmd_byte[CMD_RUN] && !run_q && !act_q |=> act_q && reload_q);
  // R5: start while active never kicks
  a_r5_no_kick_busy: assert property (@(posedge clk) disable iff (!rst_n)
    act_q |=> !kick_q);
  // R8: rising drive interrupt reaches host and status
  a_r8_irq_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drv_irq) |=> host_irq_q && irqst_q);
  // R8: falling drive interrupt leaves status alone
  a_r8_irq_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(drv_irq) && !stat_we |=> !host_irq_q && $stable(irqst_q));
  // R9: write-one clears interrupt flag without a new edge
  a_r9_w1c_irq: assert property (@(posedge clk) disable iff (!rst_n)
    stat_we && stat_byte[ST_IRQ] && !$rose(drv_irq) |=> !irqst_q);
  // R10: completion loads active from more
  a_r10_done: assert property (@(posedge clk) disable iff (!rst_n)
    eng_done && !cmd_we |=> act_q == $past(eng_more));
  // strobes are exclusive in any cycle
  a_r4_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cancel_q, reload_q}));

endmodule

// File: rtl/dma_ctl_regs.sv
module dma_ctl_regs
  import dma_ctl_pkg::*;
#(
  parameter int AW     = 32,
  parameter int DATA_W = 32,
  localparam int NLANES = LANE_BASE + AW / 8,
  localparam int OFF_W  = $clog2(NLANES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [OFF_W-1:0]  reg_off,
  input  logic [1:0]        reg_size,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              drv_irq,
  output logic              host_irq,
  input  logic              eng_req_pending,
  input  logic              eng_done,
  input  logic              eng_more,
  input  logic              eng_err,
  output logic              eng_kick,
  output logic              eng_cancel,
  output logic              eng_reload,
  output logic              eng_dir,
  output logic [AW-1:0]     tbl_ptr
);

  localparam int NB    = AW / 8;
  localparam int IMG_W = NLANES * 8;

  logic [NLANES-1:0]      lane_we;
  logic [NLANES-1:0][7:0] lane_byte;
  logic [IMG_W-1:0]       image;
  logic [AW-1:0]          base_q;
  logic                   run_q, act_q, err_q, irqst_q, load_ptr;
  logic [7:0]             cmd_view, stat_view;

  always_comb begin
    cmd_view            = '0;
    cmd_view[CMD_RUN]   = run_q;
    cmd_view[CMD_DIR]   = eng_dir;
    stat_view           = '0;
    stat_view[ST_ACTIVE] = act_q;
    stat_view[ST_ERR]    = err_q;
    stat_view[ST_IRQ]    = irqst_q;
    image = {base_q, 8'h00, stat_view, 8'h00, cmd_view};
  end

  dma_ctl_lanes #(.NLANES(NLANES), .DATA_W(DATA_W)) u_lanes (
    .wr        (reg_wr),
    .off       (reg_off),
    .size      (reg_size),
    .wdata     (reg_wdata),
    .image     (image),
    .lane_we   (lane_we),
    .lane_byte (lane_byte),
    .rdata     (reg_rdata)
  );

  dma_ctl_cmd u_cmd (
    .clk             (clk),
    .rst_n           (rst_n),
    .cmd_we          (lane_we[LANE_CMD]),
    .cmd_byte        (lane_byte[LANE_CMD]),
    .stat_we         (lane_we[LANE_STAT]),
    .stat_byte       (lane_byte[LANE_STAT]),
    .drv_irq         (drv_irq),
    .eng_req_pending (eng_req_pending),
    .eng_done        (eng_done),
    .eng_more        (eng_more),
    .eng_err         (eng_err),
    .run_q           (run_q),
    .dir_q           (eng_dir),
    .act_q           (act_q),
    .err_q           (err_q),
    .irqst_q         (irqst_q),
    .host_irq_q      (host_irq),
    .kick_q          (eng_kick),
    .cancel_q        (eng_cancel),
    .reload_q        (eng_reload),
    .load_ptr        (load_ptr)
  );

  dma_ctl_base #(.AW(AW)) u_base (
    .clk       (clk),
    .rst_n     (rst_n),
    .lane_we   (lane_we[LANE_BASE +: NB]),
    .lane_byte (lane_byte[LANE_BASE +: NB]),
    .load_ptr  (load_ptr),
    .base_q    (base_q),
    .ptr_q     (tbl_ptr)
  );

  // R2: direction output follows stored command bit 3
  a_r2_dir_write: assert property (@(posedge clk) disable iff (!rst_n)
    lane_we[LANE_CMD] |=> eng_dir == $past(reg_wdata[CMD_DIR] && reg_off == '0));
  // R9: software cannot set the active flag
  a_r9_active_ro: assert property (@(posedge clk) disable iff (!rst_n)
    !act_q && !lane_we[LANE_CMD] && !eng_done |=> !act_q);

endmodule

// File: tb/dma_ctl_regs_test.sv
`timescale 1ns/1ps
module dma_ctl_regs_test;

  logic        clk;
  logic        rst_n;
  logic        reg_wr;
  logic [2:0]  reg_off;
  logic [1:0]  reg_size;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        drv_irq, host_irq;
  logic        eng_req_pending, eng_done, eng_more, eng_err;
  logic        eng_kick, eng_cancel, eng_reload, eng_dir;
  logic [31:0] tbl_ptr;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  dma_ctl_regs uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_off(reg_off),
    .reg_size(reg_size), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .drv_irq(drv_irq), .host_irq(host_irq),
    .eng_req_pending(eng_req_pending), .eng_done(eng_done),
    .eng_more(eng_more), .eng_err(eng_err), .eng_kick(eng_kick),
    .eng_cancel(eng_cancel), .eng_reload(eng_reload), .eng_dir(eng_dir),
    .tbl_ptr(tbl_ptr)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // behavioural reference model
  bit       m_run, m_dir, m_act, m_err, m_irq, m_hirq;
  bit       m_kick, m_cancel, m_reload;
  bit [31:0] m_base, m_ptr;

  function automatic int nbytes_of(input logic [1:0] s);
    return (s == 2'd0) ? 1 : (s == 2'd1) ? 2 : 4;
  endfunction

  function automatic logic [31:0] model_read(input logic [2:0] off, input logic [1:0] s);
    logic [63:0] img;
    logic [63:0] sh;
    logic [31:0] mask;
    img  = {m_base, 8'h00, {5'b0, m_irq, m_err, m_act}, 8'h00, {4'b0, m_dir, 2'b0, m_run}};
    sh   = img >> (8 * off);
    mask = (nbytes_of(s) == 4) ? 32'hFFFF_FFFF : ((32'd1 << (8 * nbytes_of(s))) - 32'd1);
    return sh[31:0] & mask;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_run = 0; m_dir = 0; m_act = 0; m_err = 0; m_irq = 0; m_hirq = 0;
      m_kick = 0; m_cancel = 0; m_reload = 0; m_base = 0; m_ptr = 0;
    end else begin
      bit [7:0]  b [8];
      bit        sel [8];
      bit        was_act, was_run;
      bit [31:0] old_base;
      was_act = m_act; was_run = m_run; old_base = m_base;
      m_kick = 0; m_cancel = 0; m_reload = 0;
      for (int i = 0; i < 8; i++) begin
        sel[i] = reg_wr && (i >= int'(reg_off)) && (i < int'(reg_off) + nbytes_of(reg_size));
        b[i]   = sel[i] ? 8'(reg_wdata >> (8 * (i - int'(reg_off)))) : 8'h00;
      end
      if (eng_done) m_act = eng_more;
      if (sel[2] && b[2][1]) m_err = 0;
      if (sel[2] && b[2][2]) m_irq = 0;
      if (eng_err) m_err = 1;
      if (drv_irq && !m_hirq) m_irq = 1;
      m_hirq = drv_irq;
      for (int i = 4; i < 8; i++)
        if (sel[i]) m_base[8*(i-4) +: 8] = b[i];
      m_base[1:0] = 2'b00;
      if (sel[0]) begin
        if (b[0][0] != was_run) begin
          if (!b[0][0]) begin
            m_cancel = 1; m_act = 0;
          end else begin
            m_reload = 1; m_ptr = old_base;
            if (!was_act) begin
              m_act = 1; m_kick = eng_req_pending;
            end
          end
        end
        m_run = b[0][0];
        m_dir = b[0][3];
      end
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    check("R8 host_irq", 32'(host_irq), 32'(m_hirq));
    check("R5 eng_kick", 32'(eng_kick), 32'(m_kick));
    check("R4 eng_cancel", 32'(eng_cancel), 32'(m_cancel));
    check("R5 eng_reload", 32'(eng_reload), 32'(m_reload));
    check("R2 eng_dir", 32'(eng_dir), 32'(m_dir));
    check("R5 tbl_ptr", tbl_ptr, m_ptr);
    check("R7 reg_rdata", reg_rdata, model_read(reg_off, reg_size));
  endtask

  task automatic step();
    @(negedge clk);
    compare_all();
  endtask

  task automatic wr(input logic [2:0] off, input logic [1:0] s, input logic [31:0] d);
    reg_wr = 1; reg_off = off; reg_size = s; reg_wdata = d;
    step();
    reg_wr = 0; reg_wdata = 0;
  endtask

  task automatic rd_expect(input string tag, input logic [2:0] off, input logic [1:0] s,
                           input logic [31:0] exp);
    reg_off = off; reg_size = s;
    #1;
    check(tag, reg_rdata, exp);
  endtask

  initial begin
    rst_n = 0; reg_wr = 0; reg_off = 0; reg_size = 0; reg_wdata = 0;
    drv_irq = 0; eng_req_pending = 0; eng_done = 0; eng_more = 0; eng_err = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    step();
    // R1: reset image and outputs
    rd_expect("R1 reset low word", 3'd0, 2'd2, 32'h0);
    rd_expect("R1 reset base", 3'd4, 2'd2, 32'h0);
    check("R1 reset tbl_ptr", tbl_ptr, 32'h0);

    // R6: partial base writes and forced alignment
    wr(3'd4, 2'd2, 32'h1234_5677);
    rd_expect("R6 word base", 3'd4, 2'd2, 32'h1234_5674);
    wr(3'd5, 2'd0, 32'h0000_00AB);
    rd_expect("R6 byte lane5", 3'd4, 2'd2, 32'h1234_AB74);
    wr(3'd6, 2'd1, 32'h0000_BEEF);
    rd_expect("R6 half lane6", 3'd4, 2'd2, 32'hBEEF_AB74);
    wr(3'd4, 2'd0, 32'h0000_00FF);
    rd_expect("R6 low bits zero", 3'd4, 2'd2, 32'hBEEF_ABFC);
    // R7: narrow reads at offsets
    rd_expect("R7 byte off5", 3'd5, 2'd0, 32'h0000_00AB);
    rd_expect("R7 half off6", 3'd6, 2'd1, 32'h0000_BEEF);

    // R2 + R5: start from idle with a pending request
    eng_req_pending = 1;
    wr(3'd0, 2'd0, 32'h0000_00FF);
    check("R5 kick on idle start", 32'(eng_kick), 32'd1);
    check("R5 ptr from base", tbl_ptr, 32'hBEEF_ABFC);
    rd_expect("R2 cmd mask", 3'd0, 2'd0, 32'h0000_0009);
    rd_expect("R9 active set", 3'd2, 2'd0, 32'h0000_0001);
    step();

    // R3: same run value is ignored
    wr(3'd0, 2'd0, 32'h0000_0001);
    check("R3 no reload", 32'(eng_reload), 32'd0);
    rd_expect("R3 still active", 3'd2, 2'd0, 32'h0000_0001);
    check("R2 dir cleared", 32'(eng_dir), 32'd0);

    // R4: stop
    wr(3'd0, 2'd0, 32'h0000_0000);
    check("R4 cancel pulse", 32'(eng_cancel), 32'd1);
    rd_expect("R4 inactive", 3'd2, 2'd0, 32'h0);
    step();
    check("R4 cancel one cycle", 32'(eng_cancel), 32'd0);

    // R5: start without pending request
    eng_req_pending = 0;
    wr(3'd4, 2'd2, 32'h0000_1000);
    wr(3'd0, 2'd0, 32'h0000_0001);
    check("R5 no kick without request", 32'(eng_kick), 32'd0);
    check("R5 reload ptr", tbl_ptr, 32'h0000_1000);

    // R10: completion
    eng_done = 1; eng_more = 1; step();
    rd_expect("R10 more keeps active", 3'd2, 2'd0, 32'h1);
    eng_more = 0; step();
    eng_done = 0;
    rd_expect("R10 done clears active", 3'd2, 2'd0, 32'h0);
    wr(3'd0, 2'd0, 32'h0000_0000);

    // R5: start while already active gives no kick
    eng_done = 1; eng_more = 1; step(); eng_done = 0; eng_more = 0;
    eng_req_pending = 1;
    wr(3'd0, 2'd0, 32'h0000_0001);
    check("R5 busy start no kick", 32'(eng_kick), 32'd0);
    check("R5 busy start reload", 32'(eng_reload), 32'd1);
    wr(3'd0, 2'd0, 32'h0000_0000);

    // R8: interrupt path
    drv_irq = 1; step();
    check("R8 host follows high", 32'(host_irq), 32'd1);
    rd_expect("R8 status irq", 3'd2, 2'd0, 32'h4);
    drv_irq = 0; step();
    check("R8 host follows low", 32'(host_irq), 32'd0);
    rd_expect("R8 status kept", 3'd2, 2'd0, 32'h4);

    // R9: write-one-to-clear, set wins
    eng_done = 1; eng_more = 1; step(); eng_done = 0; eng_more = 0;
    wr(3'd2, 2'd0, 32'h0000_0007);
    rd_expect("R9 irq cleared active kept", 3'd2, 2'd0, 32'h1);
    eng_err = 1; step(); eng_err = 0;
    rd_expect("R9 err set", 3'd2, 2'd0, 32'h3);
    eng_err = 1;
    wr(3'd2, 2'd0, 32'h0000_0002);
    eng_err = 0;
    rd_expect("R9 set beats clear", 3'd2, 2'd0, 32'h3);
    wr(3'd0, 2'd2, 32'h0002_0000);
    rd_expect("R9 cleared via word write", 3'd0, 2'd2, 32'h0001_0000);
    drv_irq = 1;
    wr(3'd2, 2'd0, 32'h0000_0004);
    drv_irq = 0;
    rd_expect("R9 rise beats clear", 3'd2, 2'd0, 32'h5);

    repeat (4) step();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #400000;
    if (!finished) begin
      fails++;
      $display("FAIL watchdog R1 actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule